// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block keeps the 8-bit status word that a flash memory's program/erase controller shows to the host. A simplified internal sequencer sends it one-cycle strobes: program start, erase start, operation done, suspend, resume, and three failure kinds (programming-supply fault, write to a protected block, cell failure). The block tracks which operation is running or suspended. It keeps the error flags, and it assembles the word that a read returns. The ready output repeats the busy/ready bit.

The error flags are sticky. Only a clear-status command or the synchronous reset removes them. A protection hit that is never cleared also makes every later program or erase report failure. One program may run inside a suspended erase, and the erase-suspended flag stays up while it runs. When the bus-mode select chooses address-multiplexed mode, the protection bit reads as zero. The stored flag is not lost.

Bit map of `stat_o`:
- bit 7: ready
- bit 6: erase suspended
- bit 5: erase error
- bit 4: program error
- bit 3: supply fault
- bit 2: program suspended
- bit 1: protection hit
- bit 0: reserved

Top module: `fpe_status_reg`

## Requirements
- R1: While `rst` is sampled high, the register returns to idle. On the following cycle `stat_o` reads 0x80 and `ready_o` reads 1.
- R2: A program start or erase start accepted at idle clears bit 7 from the next cycle. `ready_o` always equals bit 7.
- R3: Operation done ends a running program or erase. Bit 7 goes to 1, and with no stored protection hit no error bit is set.
- R4: Suspend during a running program sets bit 2 and bit 7. A later resume clears both bits, and the program continues.
- R5: Suspend during an erase sets bits 6 and 7. A program started in that state clears bit 7 and keeps bit 6. When that program ends, the register returns to bits 6 and 7 set. Resume clears bit 6 and restarts the erase.
- R6: A supply fault during a running operation sets bit 3. It also sets bit 4 for a program or bit 5 for an erase, and it ends the operation. A failure strobe that arrives in the same cycle as done takes priority over done.
- R7: A protection hit during a running operation sets bit 1, plus bit 4 for a program or bit 5 for an erase, and ends the operation.
- R8: A cell failure during a running operation sets only bit 4 for a program or only bit 5 for an erase, and ends the operation.
- R9: Bits 5, 4, 3 and 1 stay set until clear-status or reset. Clear-status leaves bits 7, 6 and 2 unchanged. An error that arrives in the same cycle as clear-status remains set.
- R10: While a protection hit is stored, any later program or erase that ends with done also sets its own error bit, bit 4 or bit 5.
- R11: With `hostbus_mode_i` low, bit 1 reads 0. The stored flag shows again once the input returns high.
- R12: Bit 0 always reads 0.
- R13: The following are ignored: suspend when nothing runs, resume when nothing is suspended, any start while an operation runs, erase start during an erase suspend, suspend during a program nested in an erase suspend, and failure strobes when nothing runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| hostbus_mode_i | input | 1 | 1: host-bus mode, 0: address-multiplexed mode |
| clr_stat_i | input | 1 | Clear-status command strobe |
| pgm_start_i | input | 1 | Program start strobe |
| ers_start_i | input | 1 | Erase start strobe |
| done_i | input | 1 | Operation done strobe |
| suspend_i | input | 1 | Suspend command strobe |
| resume_i | input | 1 | Resume command strobe |
| vpp_fault_i | input | 1 | Programming-supply fault strobe |
| prot_hit_i | input | 1 | Protected-block write attempt strobe |
| cell_fail_i | input | 1 | Cell failure strobe |
| stat_o | output | 8 | Status word |
| ready_o | output | 1 | Ready flag, equal to bit 7 |

## Verification
A wrong sequencer state appears at the ports in the cycle right after the strobe that caused it. It shows as bit 7, 6 or 2 disagreeing with the sequence of commands applied so far. A lost or spurious sticky flag also shows on the next cycle. It can hide under a later, legitimate error of the same kind, so the bench reads the word after each single event and again after clear-status. The same applies to a protection flag masked in multiplexed mode, which the bench reads in both bus modes. A missing failure on an operation started after an uncleared protection hit shows only at that operation's done, which can be many cycles after the hit.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int STAT_W  = 8;
  localparam int B_READY = 7;
  localparam int B_ESUSP = 6;
  localparam int B_EERR  = 5;
  localparam int B_PERR  = 4;
  localparam int B_VPP   = 3;
  localparam int B_PSUSP = 2;
  localparam int B_PROT  = 1;
  localparam int B_RSVD  = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM,
    ST_ERS,
    ST_PSUSP,
    ST_ESUSP,
    ST_NPGM
  } op_state_e;
endpackage

// File: rtl/fpe_op_fsm.sv
module fpe_op_fsm
  import fpe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pgm_start,
  input  logic      ers_start,
  input  logic      done,
  input  logic      suspend,
  input  logic      resume,
  input  logic      fault,
  output op_state_e state_q,
  output logic      pgm_active,
  output logic      ers_active
);
  op_state_e state_d;

  // priority inside a state: failure/done, then suspend/resume, then start
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pgm_start)      state_d = ST_PGM;
        else if (ers_start) state_d = ST_ERS;
      end
      ST_PGM: begin
        if (fault || done) state_d = ST_IDLE;
        else if (suspend)  state_d = ST_PSUSP;
      end
      ST_ERS: begin
        if (fault || done) state_d = ST_IDLE;
        else if (suspend)  state_d = ST_ESUSP;
      end
      ST_PSUSP: begin
        if (resume) state_d = ST_PGM;
      end
      ST_ESUSP: begin
        if (resume)         state_d = ST_ERS;
        else if (pgm_start) state_d = ST_NPGM;
      end
      ST_NPGM: begin
        if (fault || done) state_d = ST_ESUSP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign pgm_active = (state_q == ST_PGM) || (state_q == ST_NPGM);
  assign ers_active = (state_q == ST_ERS);
endmodule

// File: rtl/fpe_err_flags.sv
module fpe_err_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pgm_active,
  input  logic ers_active,
  input  logic done,
  input  logic vpp_fault,
  input  logic prot_hit,
  input  logic cell_fail,
  output logic vpp_q,
  output logic prot_q,
  output logic perr_q,
  output logic eerr_q
);
  logic active;
  logic fault_any;
  logic op_fails;

  assign active    = pgm_active || ers_active;
  assign fault_any = vpp_fault || prot_hit || cell_fail;
  // a stored protection hit turns a normal completion into a failure
  assign op_fails  = fault_any || (done && prot_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      vpp_q  <= 1'b0;
      prot_q <= 1'b0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else begin
      if (clr) begin
        vpp_q  <= 1'b0;
        prot_q <= 1'b0;
        perr_q <= 1'b0;
        eerr_q <= 1'b0;
      end
      // set terms follow the clear, so a same-cycle error survives it
      if (active && vpp_fault)    vpp_q  <= 1'b1;
      if (active && prot_hit)     prot_q <= 1'b1;
      if (pgm_active && op_fails) perr_q <= 1'b1;
      if (ers_active && op_fails) eerr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fpe_status_reg.sv
module fpe_status_reg
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hostbus_mode_i,
  input  logic              clr_stat_i,
  input  logic              pgm_start_i,
  input  logic              ers_start_i,
  input  logic              done_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              vpp_fault_i,
  input  logic              prot_hit_i,
  input  logic              cell_fail_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              ready_o
);
  op_state_e st_q;
  logic      pgm_act, ers_act;
  logic      vpp_q, prot_q, perr_q, eerr_q;
  logic      fault_any;

  assign fault_any = vpp_fault_i || prot_hit_i || cell_fail_i;

  fpe_op_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pgm_start  (pgm_start_i),
    .ers_start  (ers_start_i),
    .done       (done_i),
    .suspend    (suspend_i),
    .resume     (resume_i),
    .fault      (fault_any),
    .state_q    (st_q),
    .pgm_active (pgm_act),
    .ers_active (ers_act)
  );

  fpe_err_flags u_err (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_stat_i),
    .pgm_active (pgm_act),
    .ers_active (ers_act),
    .done       (done_i),
    .vpp_fault  (vpp_fault_i),
    .prot_hit   (prot_hit_i),
    .cell_fail  (cell_fail_i),
    .vpp_q      (vpp_q),
    .prot_q     (prot_q),
    .perr_q     (perr_q),
    .eerr_q     (eerr_q)
  );

  always_comb begin
    stat_o          = '0;
    stat_o[B_READY] = !(pgm_act || ers_act);
    stat_o[B_ESUSP] = (st_q == ST_ESUSP) || (st_q == ST_NPGM);
    stat_o[B_EERR]  = eerr_q;
    stat_o[B_PERR]  = perr_q;
    stat_o[B_VPP]   = vpp_q;
    stat_o[B_PSUSP] = (st_q == ST_PSUSP);
    stat_o[B_PROT]  = prot_q && hostbus_mode_i;
    stat_o[B_RSVD]  = 1'b0;
  end

  assign ready_o = stat_o[B_READY];
endmodule

// File: rtl/fpe_status_sva.sv
module fpe_status_sva (
  input logic       clk,
  input logic       rst,
  input logic       hostbus_mode_i,
  input logic       clr_stat_i,
  input logic       pgm_start_i,
  input logic       ers_start_i,
  input logic       done_i,
  input logic       suspend_i,
  input logic       resume_i,
  input logic       vpp_fault_i,
  input logic       prot_hit_i,
  input logic       cell_fail_i,
  input logic [7:0] stat_o,
  input logic       ready_o
);
  logic any_ev;
  assign any_ev = pgm_start_i || ers_start_i || done_i || suspend_i || resume_i ||
                  vpp_fault_i || prot_hit_i || cell_fail_i;

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (stat_o == 8'h80 && ready_o));

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    stat_o[0] == 1'b0);

  a_r11_mux_masks_prot: assert property (@(posedge clk) disable iff (rst)
    !hostbus_mode_i |-> !stat_o[1]);

  a_r9_sticky_errors: assert property (@(posedge clk) disable iff (rst)
    !clr_stat_i |=> ((stat_o[5:3] & $past(stat_o[5:3])) == $past(stat_o[5:3])));

  a_r9_clear_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (clr_stat_i && !any_ev) |=>
      (stat_o[7] == $past(stat_o[7]) && stat_o[6] == $past(stat_o[6]) &&
       stat_o[2] == $past(stat_o[2])));

  a_r4_psusp_is_ready: assert property (@(posedge clk) disable iff (rst)
    stat_o[2] |-> (stat_o[7] && !stat_o[6]));

  a_r4_resume_runs: assert property (@(posedge clk) disable iff (rst)
    (stat_o[2] && resume_i) |=> (!stat_o[2] && !stat_o[7]));
endmodule

bind fpe_status_reg fpe_status_sva u_sva (.*);

// File: tb/tb_fpe_status_reg.sv
module tb_fpe_status_reg;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hostbus_mode_i = 1'b1;
  logic       clr_stat_i = 1'b0;
  logic       pgm_start_i = 1'b0, ers_start_i = 1'b0, done_i = 1'b0;
  logic       suspend_i = 1'b0, resume_i = 1'b0;
  logic       vpp_fault_i = 1'b0, prot_hit_i = 1'b0, cell_fail_i = 1'b0;
  logic [7:0] stat_o;
  logic       ready_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpe_status_reg dut (.*);

  // event bits: 0 pgm, 1 ers, 2 done, 3 susp, 4 resume, 5 vpp, 6 prot, 7 cell, 8 clr
  task automatic pulse(input logic [8:0] ev);
    @(negedge clk);
    pgm_start_i = ev[0]; ers_start_i = ev[1]; done_i = ev[2];
    suspend_i = ev[3]; resume_i = ev[4]; vpp_fault_i = ev[5];
    prot_hit_i = ev[6]; cell_fail_i = ev[7]; clr_stat_i = ev[8];
    @(negedge clk);
    {pgm_start_i, ers_start_i, done_i, suspend_i, resume_i,
     vpp_fault_i, prot_hit_i, cell_fail_i, clr_stat_i} = '0;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (stat_o !== exp || ready_o !== exp[7]) begin
      n_fail++;
      $display("FAIL %s: stat=%h ready=%b expected stat=%h ready=%b",
               req, stat_o, ready_o, exp, exp[7]);
    end
  endtask

  localparam logic [8:0] E_PGM = 9'h001, E_ERS = 9'h002, E_DONE = 9'h004,
                         E_SUSP = 9'h008, E_RES = 9'h010, E_VPP = 9'h020,
                         E_PROT = 9'h040, E_CELL = 9'h080, E_CLR = 9'h100;

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset value", 8'h80);
    chk("R12 reserved bit", 8'h80);
  endtask

  task automatic t_normal();
    pulse(E_PGM);  chk("R2 program busy", 8'h00);
    pulse(E_DONE); chk("R3 program done", 8'h80);
    pulse(E_ERS);  chk("R2 erase busy", 8'h00);
    pulse(E_DONE); chk("R3 erase done", 8'h80);
  endtask

  task automatic t_psusp();
    pulse(E_PGM);
    pulse(E_SUSP); chk("R4 program suspended", 8'h84);
    pulse(E_RES);  chk("R4 program resumed", 8'h00);
    pulse(E_DONE); chk("R4 done after resume", 8'h80);
  endtask

  task automatic t_nested();
    pulse(E_ERS);
    pulse(E_SUSP); chk("R5 erase suspended", 8'hC0);
    pulse(E_PGM);  chk("R5 program in erase suspend", 8'h40);
    pulse(E_DONE); chk("R5 back to erase suspend", 8'hC0);
    pulse(E_RES);  chk("R5 erase resumed", 8'h00);
    pulse(E_DONE); chk("R5 erase done", 8'h80);
  endtask

  task automatic t_ignored();
    pulse(E_SUSP); chk("R13 suspend at idle", 8'h80);
    pulse(E_RES);  chk("R13 resume at idle", 8'h80);
    pulse(E_VPP | E_PROT | E_CELL); chk("R13 faults at idle", 8'h80);
    pulse(E_PGM);
    pulse(E_ERS);  chk("R13 start while busy", 8'h00);
    pulse(E_DONE); chk("R13 program-only completion", 8'h80);
    pulse(E_ERS);
    pulse(E_SUSP);
    pulse(E_ERS);  chk("R13 erase start in erase suspend", 8'hC0);
    pulse(E_PGM);
    pulse(E_SUSP); chk("R13 suspend of nested program", 8'h40);
    pulse(E_DONE);
    pulse(E_RES);
    pulse(E_DONE); chk("R13 cleanup", 8'h80);
  endtask

  task automatic t_faults();
    pulse(E_PGM); pulse(E_VPP);  chk("R6 program supply fault", 8'h98);
    pulse(E_CLR);                chk("R9 clear errors", 8'h80);
    pulse(E_ERS); pulse(E_VPP);  chk("R6 erase supply fault", 8'hA8);
    pulse(E_CLR);
    pulse(E_PGM); pulse(E_CELL); chk("R8 program cell fail", 8'h90);
    pulse(E_CLR);
    pulse(E_ERS); pulse(E_CELL); chk("R8 erase cell fail", 8'hA0);
    pulse(E_CLR);
    pulse(E_ERS); pulse(E_DONE | E_CELL); chk("R6 fault beats done", 8'hA0);
    pulse(E_CLR);
    pulse(E_PGM); pulse(E_VPP | E_CLR);   chk("R9 error beats clear", 8'h98);
    pulse(E_CLR);                          chk("R9 cleared", 8'h80);
  endtask

  task automatic t_prot();
    pulse(E_PGM); pulse(E_PROT); chk("R7 program protection hit", 8'h92);
    pulse(E_ERS);  chk("R9 flags kept across new erase", 8'h12);
    pulse(E_DONE); chk("R10 erase fails after stored hit", 8'hB2);
    @(negedge clk); hostbus_mode_i = 1'b0;
    #1 chk("R11 mux mode masks bit1", 8'hB0);
    @(negedge clk); hostbus_mode_i = 1'b1;
    #1 chk("R11 host mode shows bit1", 8'hB2);
    pulse(E_CLR);  chk("R9 clear protection", 8'h80);
    pulse(E_ERS); pulse(E_PROT); chk("R7 erase protection hit", 8'hA2);
    pulse(E_CLR);
    pulse(E_ERS); pulse(E_SUSP); pulse(E_PGM); pulse(E_CELL);
    chk("R8 nested program cell fail", 8'hD0);
    pulse(E_CLR);  chk("R9 clear keeps suspend and ready", 8'hC0);
    pulse(E_RES); pulse(E_DONE); chk("R3 final", 8'h80);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    t_reset();
    t_normal();
    t_psusp();
    t_nested();
    t_ignored();
    t_faults();
    t_prot();
    t_reset();
    report();
  end
endmodule